// File: doc/BRIEF.md
# Multi-Channel PWM Controller

A peripheral that drives several independent pulse-width-modulated output pins. Software programs it through a small memory-mapped register bus with an address, write data, a write strobe, a read strobe and registered read data. One shared word starts and stops the channels. Each channel has its own register window, which holds a control word, a period count and a duty threshold.

Each channel runs a power-of-two prescaler that feeds a period counter. The pin is high while the counter is below the threshold. New settings are copied into the running channel only when a period ends, so a write during operation never produces a shortened or stretched pulse.

A shared source-select register chooses what advances the prescalers. It can be every bus clock, or only those cycles on which an external reference strobe is high.

Top module: `multi_pwm_ctrl`

## Requirements
- R1: The word at address 0x000 holds one run bit per channel, with bit n belonging to channel n. It reads back as written, so software can set or clear single bits with a read-modify-write.
- R2: Channel n's window starts at 0x010 + n*0x040.
  - At +0x00 is the control word. Bits [2:0] are the prescale exponent and bit 15 is the waveform-mode bit. It reads back only those bits.
  - At +0x2C is the 13-bit period.
  - At +0x30 is the 13-bit threshold.
  - Both counts read back masked to 13 bits.
- R3: With exponent e, the counter advances once every 2^e prescaler steps. The output period is therefore period*2^e clock cycles, for every e from 0 to 7.
- R4: The counter runs from 0 to period-1 and then wraps. The output is high while the count is below the threshold, giving threshold*2^e high cycles in each period.
- R5: A threshold equal to or above the period keeps the output high all the time. A period of 0, or a threshold of 0, keeps it low.
- R6: While the mode bit of the running settings is clear, the output stays low.
- R7: Period, threshold, exponent and mode written while a channel runs take effect only at the next period boundary. The pulse in progress completes with the old values.
- R8: Clearing a channel's run bit drives its output low within two cycles and clears its counter and prescaler. Setting the bit again starts a full first pulse, beginning one cycle after the write. Channels whose run bit is clear stay low.
- R9: The word at 0x210 selects the step source. A value of 0 means every clock. Any nonzero value means only cycles with alt_tick high; with alt_tick held low the outputs freeze. The register reads back as 1 or 0.
- R10: A read returns data in the cycle after the read strobe. Addresses that are not mapped read as zero.
- R11: After reset, every register reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| alt_tick | input | 1 | Alternate-reference step strobe |
| pwm_out | output | NUM_CH | One waveform pin per channel |

## Verification
Every cycle, the assertions check four things:
- the prescaler count never passes its limit;
- the period counter stays below a nonzero period;
- the running settings do not change between period boundaries while a channel runs;
- a stopped channel's pin goes low the next cycle and the run word changes only on a write to it.

Only the bench's scenarios can show the waveform itself. That covers high-cycle counts over whole periods for each exponent, the constant-high and constant-low cases, an unbroken pulse across a mid-period reprogramming, the restart after re-enable, and the slowed or frozen pattern under the alternate source.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PRESC_W  = 3;
  localparam int CNT_W    = 13;
  localparam int DATA_W   = 32;
  localparam int MODE_BIT = 15;

  typedef struct packed {
    logic               mode;
    logic [PRESC_W-1:0] presc;
    logic [CNT_W-1:0]   period;
    logic [CNT_W-1:0]   thresh;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             src_ok,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int PC_W = (1 << EXP_W) - 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] lim;

  // Terminal count is 2^exp - 1.
  assign lim    = ~({PC_W{1'b1}} << exp_i);
  assign tick_o = run && src_ok && (pc_q == lim);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pc_q <= '0;
    end else if (src_ok) begin
      pc_q <= (pc_q == lim) ? '0 : pc_q + 1'b1;
    end
  end

  // R3: the divider count never passes the current limit
  assert_presc_bound_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (pc_q <= lim));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     src_ok,
  input  pwm_cfg_t cfg,
  output logic     pwm_o
);
  pwm_cfg_t         act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;
  logic             last;
  logic             boundary;
  logic             pwm_q;

  pwm_prescaler #(.EXP_W(PRESC_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run    (en),
    .src_ok (src_ok),
    .exp_i  (act_q.presc),
    .tick_o (tick)
  );

  assign last     = (act_q.period == '0) || (cnt_q == act_q.period - CNT_W'(1));
  assign boundary = tick && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else if (!en) begin
      act_q <= cfg;        // stopped: track software view
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      if (tick) begin
        if (last) begin
          cnt_q <= '0;
          act_q <= cfg;    // reload only at the period edge
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      pwm_q <= act_q.mode && (act_q.period != '0) && (cnt_q < act_q.thresh);
    end
  end

  assign pwm_o = pwm_q;

  // R4: counter stays inside the running period
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (en && act_q.period != '0) |-> (cnt_q < act_q.period));

  // R7: running settings hold between boundaries
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (en && !boundary) |=> (!en || $stable(act_q)));

  // R8: a stopped channel's pin is low on the following cycle
  assert_off_low_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_q);
endmodule

// File: rtl/multi_pwm_ctrl.sv
module multi_pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int ADDR_W      = 12,
  parameter int EN_ADDR     = 'h000,
  parameter int WIN_BASE    = 'h010,
  parameter int WIN_STRIDE  = 'h040,
  parameter int OFS_CTRL    = 'h00,
  parameter int OFS_PERIOD  = 'h2C,
  parameter int OFS_THRESH  = 'h30,
  parameter int CLKSEL_ADDR = 'h210
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic              alt_tick,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0] en_q;
  logic              clksel_q;
  pwm_cfg_t          cfg_q [NUM_CH];
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              src_ok;
  logic              en_hit;
  logic              csel_hit;

  assign en_hit   = (addr == ADDR_W'(EN_ADDR));
  assign csel_hit = (addr == ADDR_W'(CLKSEL_ADDR));
  assign src_ok   = !clksel_q || alt_tick;

  // Register writes and registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      clksel_q <= 1'b0;
      rdata_q  <= '0;
      for (int i = 0; i < NUM_CH; i++) cfg_q[i] <= '0;
    end else begin
      if (wr_en && en_hit)   en_q     <= wdata[NUM_CH-1:0];
      if (wr_en && csel_hit) clksel_q <= |wdata;
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr_en && addr == ADDR_W'(WIN_BASE + i*WIN_STRIDE + OFS_CTRL)) begin
          cfg_q[i].mode  <= wdata[MODE_BIT];
          cfg_q[i].presc <= wdata[PRESC_W-1:0];
        end
        if (wr_en && addr == ADDR_W'(WIN_BASE + i*WIN_STRIDE + OFS_PERIOD))
          cfg_q[i].period <= wdata[CNT_W-1:0];
        if (wr_en && addr == ADDR_W'(WIN_BASE + i*WIN_STRIDE + OFS_THRESH))
          cfg_q[i].thresh <= wdata[CNT_W-1:0];
      end
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (en_hit)   rd_mux = DATA_W'(en_q);
    if (csel_hit) rd_mux = DATA_W'(clksel_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(WIN_BASE + i*WIN_STRIDE + OFS_CTRL))
        rd_mux = (DATA_W'(cfg_q[i].mode) << MODE_BIT) | DATA_W'(cfg_q[i].presc);
      if (addr == ADDR_W'(WIN_BASE + i*WIN_STRIDE + OFS_PERIOD))
        rd_mux = DATA_W'(cfg_q[i].period);
      if (addr == ADDR_W'(WIN_BASE + i*WIN_STRIDE + OFS_THRESH))
        rd_mux = DATA_W'(cfg_q[i].thresh);
    end
  end

  assign rdata = rdata_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel u_ch (
      .clk    (clk),
      .rst    (rst),
      .en     (en_q[g]),
      .src_ok (src_ok),
      .cfg    (cfg_q[g]),
      .pwm_o  (pwm_out[g])
    );
  end

  // R1: the run word moves only on a write to its own address
  assert_en_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && en_hit) |=> $stable(en_q));
endmodule

// File: tb/tb_multi_pwm_ctrl.sv
`timescale 1ns/1ps
module tb_multi_pwm_ctrl;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic        wr_en;
  logic        rd_en;
  logic [31:0] rdata;
  logic        alt_tick = 1'b0;
  logic [NCH-1:0] pwm_out;
  logic        alt_mode = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;

  multi_pwm_ctrl dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .alt_tick(alt_tick), .pwm_out(pwm_out)
  );

  always #2 clk = ~clk;
  always @(negedge clk) alt_tick <= alt_mode ? ~alt_tick : 1'b0;

  // {presc, period, thresh, window, expected high cycles}
  localparam logic [60:0] VEC [10] = '{
    {3'd0, 13'd10,  13'd3,   16'd20,  16'd6},
    {3'd1, 13'd8,   13'd5,   16'd32,  16'd20},
    {3'd2, 13'd5,   13'd2,   16'd40,  16'd16},
    {3'd0, 13'd7,   13'd7,   16'd21,  16'd21},
    {3'd0, 13'd7,   13'd100, 16'd21,  16'd21},
    {3'd0, 13'd0,   13'd5,   16'd20,  16'd0},
    {3'd0, 13'd9,   13'd0,   16'd18,  16'd0},
    {3'd3, 13'd3,   13'd1,   16'd48,  16'd16},
    {3'd0, 13'd1,   13'd1,   16'd10,  16'd10},
    {3'd7, 13'd2,   13'd1,   16'd256, 16'd128}
  };

  function automatic int win(input int ch);
    return 'h10 + ch * 'h40;
  endfunction

  task automatic chk(input string req, input int act, input int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = a[11:0]; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr = a[11:0]; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic setup(input int ch, input int ctrl, input int per, input int thr);
    wr(win(ch), ctrl);
    wr(win(ch) + 'h2C, per);
    wr(win(ch) + 'h30, thr);
  endtask

  task automatic count_hi(input int ch, input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v, hi, other;
    rst = 1'b1; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk("R11 outputs", int'(pwm_out), 0);
    rd(0, v);              chk("R11 run word", v, 0);
    rd(win(0) + 'h2C, v);  chk("R11 period", v, 0);
    rd('h210, v);          chk("R11 source select", v, 0);

    // R2 field masking on readback
    wr(win(1) + 'h2C, 'hFFFF);   rd(win(1) + 'h2C, v); chk("R2 period mask", v, 'h1FFF);
    wr(win(1), 'hFFFFFFFF);      rd(win(1), v);        chk("R2 ctrl mask", v, 'h8007);
    wr(win(3) + 'h30, 'h2ABC);   rd(win(3) + 'h30, v); chk("R2 thresh mask", v, 'h0ABC);

    // R10 unmapped reads
    rd('h004, v); chk("R10 unmapped 0x004", v, 0);
    rd('h014, v); chk("R10 unmapped in window", v, 0);
    rd('h3FC, v); chk("R10 unmapped 0x3FC", v, 0);

    // R1 run word read-modify-write
    wr(0, 'h5); rd(0, v); chk("R1 run word", v, 5);
    wr(0, v | 'h2); rd(0, v); chk("R1 read-modify-write", v, 7);
    wr(0, 0);

    // R3 R4 R5 vector table
    for (int i = 0; i < 10; i++) begin
      int ch;
      ch = i % NCH;
      wr(0, 0);
      setup(ch, 'h8000 | int'(VEC[i][60:58]), int'(VEC[i][57:45]), int'(VEC[i][44:32]));
      wr(0, 1 << ch);
      repeat (3) @(negedge clk);
      hi = 0; other = 0;
      repeat (int'(VEC[i][31:16])) begin
        @(negedge clk);
        if (pwm_out[ch]) hi++;
        if ((pwm_out & ~(NCH'(1) << ch)) != 0) other++;
      end
      chk($sformatf("R3/R4/R5 vector %0d high cycles", i), hi, int'(VEC[i][15:0]));
      chk($sformatf("R8 idle channels low, vector %0d", i), other, 0);
    end

    // R6 mode bit clear
    wr(0, 0);
    setup(0, 'h0000, 10, 5);
    wr(0, 1);
    repeat (3) @(negedge clk);
    count_hi(0, 20, hi);
    chk("R6 mode clear keeps low", hi, 0);

    // R7 mid-period reprogramming
    wr(0, 0);
    setup(0, 'h8000, 10, 5);
    wr(0, 1);
    do @(negedge clk); while (pwm_out[0]);
    do @(negedge clk); while (!pwm_out[0]);
    wr(win(0) + 'h2C, 4);
    wr(win(0) + 'h30, 2);
    count_hi(0, 5, hi);
    chk("R7 old period completes low tail", hi, 0);
    @(negedge clk);
    chk("R7 new period starts on time", int'(pwm_out[0]), 1);
    count_hi(0, 8, hi);
    chk("R7 new values after boundary", hi, 4);

    // R8 stop and restart
    wr(0, 0);
    @(negedge clk);
    chk("R8 low after stop", int'(pwm_out[0]), 0);
    count_hi(0, 10, hi);
    chk("R8 stays low while stopped", hi, 0);
    wr(0, 1);
    @(negedge clk);
    chk("R8 restart begins high", int'(pwm_out[0]), 1);
    count_hi(0, 7, hi);
    chk("R8 full first pulses", hi + 1, 4);

    // R9 alternate step source
    wr(0, 0);
    setup(1, 'h8000, 6, 3);
    wr('h210, 5);
    rd('h210, v); chk("R9 select readback", v, 1);
    alt_mode = 1'b1;
    wr(0, 2);
    repeat (4) @(negedge clk);
    count_hi(1, 24, hi);
    chk("R9 half-rate pattern", hi, 12);
    alt_mode = 1'b0;
    repeat (2) @(negedge clk);
    count_hi(1, 10, hi);
    chk("R9 frozen output", (hi == 0 || hi == 10) ? 1 : 0, 1);
    wr('h210, 0);
    wr(0, 0);

    finish_run();
  end
endmodule